// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Test-Time System Reset

This block is a serial test port of the kind defined by IEEE 1149.1. A sixteen-state controller is stepped by the test-mode select line on each rising test-clock edge. A 4-bit instruction register sets which data register lies between the serial input and the serial output. The data register is either a one-cell bypass stage or a boundary register that wraps the chip's pins. Pads are modelled as plain vectors. The input cells come first, then one cell per output pin, then one cell per output-enable, for 520 cells at the default sizes.

Two behaviours set this port apart from the usual one. In Capture-IR the instruction shift stage loads the CLAMP opcode instead of the customary fixed pattern. While the external-test instruction is current, the block drives a reset request that holds the system logic in a known state. Crossing between the test clock and the system clock is left to the surrounding logic.

Top module: `bscan_tap`

## Requirements
- R1: In Capture-IR the instruction shift stage loads 4'b1100. It shifts least significant bit first, so a full IR scan returns the bits 0,0,1,1 in that order.
- R2: EXTEST (4'b0000) and SAMPLE/PRELOAD (4'b0001) place the boundary register between tdi and tdo. Its length is N_IN+N_OUT+N_OE cells (520 by default). Cell 0 is nearest tdo, and a bit entering at tdi appears at tdo after that many shifts.
- R3: sys_rst_req is high exactly while EXTEST is the current instruction and the controller is not in Test-Logic-Reset.
- R4: With the boundary register selected, Capture-DR loads pin_in into cells 0..N_IN-1, core_out into the next N_OUT cells and core_oe into the last N_OE cells. Under SAMPLE/PRELOAD, BYPASS or an unused code, pad_out and pad_oe follow core_out and core_oe.
- R5: BYPASS (4'b1111), CLAMP (4'b1100) and every unused code place a one-cell register between tdi and tdo.
- R6: The bypass cell loads 0 in Capture-DR, so the first bit shifted out of it is 0.
- R7: Update-DR with the boundary register selected copies the output and enable cells into the update latches. Under EXTEST or CLAMP, pad_out and pad_oe are driven from those latches.
- R8: The update latches change only in Update-DR with the boundary register selected. They hold through Shift-DR and through Update-DR on the bypass path.
- R9: Test-Logic-Reset, reached by TMS, forces the current instruction to BYPASS.
- R10: trst_n low puts the controller in Test-Logic-Reset and the instruction to BYPASS at once, without a clock edge.
- R11: tdo and tdo_en change on the falling tck edge. tdo_en is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for tdo |
| pin_in | input | N_IN | Values seen at input pads |
| core_out | input | N_OUT | Output values from system logic |
| core_oe | input | N_OE | Output enables from system logic |
| pad_out | output | N_OUT | Values driven to output pads |
| pad_oe | output | N_OE | Enables driven to three-state pads |
| sys_rst_req | output | 1 | Reset request to system logic during EXTEST |

## Verification
Two things happen on the same rising edge at Update-IR: the instruction switch to EXTEST and the handover of the pads from the core to the update latches, which were filled earlier under SAMPLE/PRELOAD. The bench preloads a known 520-bit pattern and then scans in EXTEST. Right after that scan it requires three things at once: the pads show the preloaded values, the pads show nothing of the core values, and the reset request is raised. A second pairing is a boundary scan in EXTEST, where shifting and the held pad drive coexist. The pads are sampled halfway through the shift and must still equal the preload. They change only after Update-DR.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   localparam int IR_W = 4;

   localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
   localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
   localparam logic [IR_W-1:0] OP_CLAMP  = 4'b1100;
   localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

   typedef enum logic [3:0] {
      TS_EX2_DR = 4'h0, TS_EX1_DR = 4'h1, TS_SH_DR  = 4'h2, TS_PAU_DR = 4'h3,
      TS_SEL_IR = 4'h4, TS_UPD_DR = 4'h5, TS_CAP_DR = 4'h6, TS_SEL_DR = 4'h7,
      TS_EX2_IR = 4'h8, TS_EX1_IR = 4'h9, TS_SH_IR  = 4'hA, TS_PAU_IR = 4'hB,
      TS_IDLE   = 4'hC, TS_UPD_IR = 4'hD, TS_CAP_IR = 4'hE, TS_RESET  = 4'hF
   } tap_state_t;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
   import bscan_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      case (state)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= TS_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
   import bscan_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_sr,
   output logic [IR_W-1:0] cur_ir
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                  ir_sr <= OP_CLAMP;
      else if (state == TS_CAP_IR) ir_sr <= OP_CLAMP;
      else if (state == TS_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                  cur_ir <= OP_BYPASS;
      else if (state == TS_RESET)  cur_ir <= OP_BYPASS;
      else if (state == TS_UPD_IR) cur_ir <= ir_sr;
   end

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
   parameter  int N_IN  = 200,
   parameter  int N_OUT = 200,
   parameter  int N_OE  = 120,
   localparam int LEN   = N_IN + N_OUT + N_OE,
   localparam int UPD_W = N_OUT + N_OE
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             shift_en,
   input  logic             upd_en,
   input  logic             tdi,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic [N_OE-1:0]  core_oe,
   output logic             sr_lsb,
   output logic [UPD_W-1:0] upd_lat
);

   logic [LEN-1:0] sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (cap_en)   sr <= {core_oe, core_out, pin_in};
      else if (shift_en) sr <= {tdi, sr[LEN-1:1]};
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      upd_lat <= '0;
      else if (upd_en) upd_lat <= sr[LEN-1:N_IN];
   end

   assign sr_lsb = sr[0];

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
   import bscan_pkg::*;
#(
   parameter  int N_IN     = 200,
   parameter  int N_OUT    = 200,
   parameter  int N_OE     = 120,
   parameter  bit HAS_TRST = 1'b1,
   localparam int UPD_W    = N_OUT + N_OE
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_en,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic [N_OE-1:0]  core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic [N_OE-1:0]  pad_oe,
   output logic             sys_rst_req
);

   generate
      if (N_IN < 1 || N_OUT < 1 || N_OE < 1) begin : g_bad_size
         $error("bscan_tap: every cell group needs at least one cell");
      end
   endgenerate

   logic            tap_rst_n;
   tap_state_t      state;
   logic [IR_W-1:0] ir_sr, cur_ir;
   logic            byp_q, bsr_lsb, sel_bsr, pins_from_lat;
   logic            in_sh_dr, in_sh_ir;
   logic [UPD_W-1:0] upd_lat;

   generate
      if (HAS_TRST) begin : g_trst
         assign tap_rst_n = trst_n;
      end else begin : g_no_trst
         assign tap_rst_n = 1'b1;
      end
   endgenerate

   bscan_fsm u_fsm (
      .tck(tck), .rst_n(tap_rst_n), .tms(tms), .state(state)
   );

   bscan_ir u_ir (
      .tck(tck), .rst_n(tap_rst_n), .state(state), .tdi(tdi),
      .ir_sr(ir_sr), .cur_ir(cur_ir)
   );

   assign sel_bsr       = (cur_ir == OP_EXTEST) || (cur_ir == OP_SAMPLE);
   assign pins_from_lat = (cur_ir == OP_EXTEST) || (cur_ir == OP_CLAMP);
   assign sys_rst_req   = (cur_ir == OP_EXTEST) && (state != TS_RESET);
   assign in_sh_dr      = (state == TS_SH_DR);
   assign in_sh_ir      = (state == TS_SH_IR);

   bscan_bsr #(.N_IN(N_IN), .N_OUT(N_OUT), .N_OE(N_OE)) u_bsr (
      .tck(tck), .rst_n(tap_rst_n),
      .cap_en(sel_bsr && state == TS_CAP_DR),
      .shift_en(sel_bsr && in_sh_dr),
      .upd_en(sel_bsr && state == TS_UPD_DR),
      .tdi(tdi), .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
      .sr_lsb(bsr_lsb), .upd_lat(upd_lat)
   );

   always_ff @(posedge tck or negedge tap_rst_n) begin
      if (!tap_rst_n)              byp_q <= 1'b0;
      else if (state == TS_CAP_DR) byp_q <= 1'b0;
      else if (in_sh_dr)           byp_q <= tdi;
   end

   always_ff @(negedge tck or negedge tap_rst_n) begin
      if (!tap_rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= in_sh_dr || in_sh_ir;
         tdo    <= in_sh_ir ? ir_sr[0] : (sel_bsr ? bsr_lsb : byp_q);
      end
   end

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_out_pad
         assign pad_out[i] = pins_from_lat ? upd_lat[i] : core_out[i];
      end
      for (genvar j = 0; j < N_OE; j++) begin : g_oe_pad
         assign pad_oe[j] = pins_from_lat ? upd_lat[N_OUT+j] : core_oe[j];
      end
   endgenerate

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
   import bscan_pkg::*;
#(
   parameter int UPD_W = 320
) (
   input logic             tck,
   input logic             rst_n,
   input tap_state_t       state,
   input logic [IR_W-1:0]  ir_sr,
   input logic [IR_W-1:0]  cur_ir,
   input logic             byp_q,
   input logic             sel_bsr,
   input logic             tdo_en,
   input logic [UPD_W-1:0] upd_lat
);

   // R1
   ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_IR) |=> (ir_sr == OP_CLAMP));

   // R6
   bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_DR && !sel_bsr) |=> (byp_q == 1'b0));

   // R8
   latch_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state != TS_UPD_DR || !sel_bsr) |=> $stable(upd_lat));

   // R9
   reset_bypass_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_RESET) |=> (cur_ir == OP_BYPASS));

   // R11
   tdo_enable_chk: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_en == (state == TS_SH_DR || state == TS_SH_IR));

endmodule

bind bscan_tap bscan_tap_chk #(.UPD_W(UPD_W)) u_chk (
   .tck(tck), .rst_n(tap_rst_n), .state(state), .ir_sr(ir_sr),
   .cur_ir(cur_ir), .byp_q(byp_q), .sel_bsr(sel_bsr), .tdo_en(tdo_en),
   .upd_lat(upd_lat)
);

// File: tb/bscan_tap_test.sv
module bscan_tap_test;

   localparam int NI   = 200;
   localparam int NO   = 200;
   localparam int NE   = 120;
   localparam int LEN  = NI + NO + NE;
   localparam int MAXB = LEN + 8;

   // {opcode[3:0], expect reset request, expect boundary path}
   localparam logic [5:0] VEC [6] = '{
      6'b0000_1_1, 6'b0001_0_1, 6'b1100_0_0,
      6'b1111_0_0, 6'b0101_0_0, 6'b1010_0_0
   };

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic          tdo, tdo_en, sys_rst_req;
   logic [NI-1:0] pin_in;
   logic [NO-1:0] core_out, pad_out;
   logic [NE-1:0] core_oe, pad_oe;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [NO-1:0] mid_out;
   logic [NE-1:0] mid_oe;
   logic          first_en;

   bscan_tap uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .tdo_en(tdo_en), .pin_in(pin_in), .core_out(core_out),
      .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
      .sys_rst_req(sys_rst_req)
   );

   always #10 tck = ~tck;

   task automatic verify(input bit ok, input string req,
                         input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      o = tdo;
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #2;
   endtask

   task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 4; i++) step(i == 3, code[i], cap[i]);
      step(1, 0, o); step(0, 0, o);
   endtask

   task automatic dr_scan(input int n, input logic [MAXB-1:0] din,
                          output logic [MAXB-1:0] dout);
      logic o;
      dout = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      first_en = tdo_en;
      for (int i = 0; i < n; i++) begin
         if (i == n / 2) begin
            mid_out = pad_out;
            mid_oe  = pad_oe;
         end
         step(i == n - 1, din[i], dout[i]);
      end
      step(1, 0, o); step(0, 0, o);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [3:0]      cap;
      logic [MAXB-1:0] dout, pvec, qvec, snap;
      logic            o;

      for (int i = 0; i < NI; i++) pin_in[i]   = (i % 3 == 0);
      for (int i = 0; i < NO; i++) core_out[i] = (i % 5 == 1);
      for (int i = 0; i < NE; i++) core_oe[i]  = (i % 2 == 0);
      snap = '0;
      snap[LEN-1:0] = {core_oe, core_out, pin_in};
      pvec = '0;
      qvec = '0;
      for (int i = 0; i < MAXB; i++) begin
         pvec[i] = ((i * 7) % 11) < 5;
         qvec[i] = ((i * 5) % 13) < 6;
      end

      repeat (3) @(negedge tck);
      #2;
      // R10 reset state
      verify(tdo_en == 0 && sys_rst_req == 0, "R10 reset outputs",
             {tdo_en, sys_rst_req}, 0);
      verify(pad_out == core_out && pad_oe == core_oe, "R10 pads follow core in reset",
             {pad_oe, pad_out}, {core_oe, core_out});
      trst_n = 1'b1;
      step(0, 0, o);

      // table walk: opcode, IR capture, reset request, path select
      foreach (VEC[k]) begin
         logic [7:0] pat, exp8;
         pat = 8'b1011_0010;
         ir_scan(VEC[k][5:2], cap);
         verify(cap == 4'b1100, "R1 IR capture", cap, 4'b1100);
         verify(sys_rst_req == VEC[k][1], "R3 reset request by opcode",
                sys_rst_req, VEC[k][1]);
         dr_scan(8, {520'b0, pat}, dout);
         exp8 = VEC[k][0] ? pin_in[7:0] : {pat[6:0], 1'b0};
         verify(dout[7:0] == exp8, VEC[k][0] ? "R2 boundary path" : "R5 R6 bypass path",
                dout[7:0], exp8);
         verify(first_en == 1 && tdo_en == 0, "R11 tdo_en shift only",
                {first_en, tdo_en}, 2'b10);
      end

      // SAMPLE/PRELOAD: full snapshot and preload
      ir_scan(4'b0001, cap);
      dr_scan(LEN, pvec, dout);
      verify(dout[LEN-1:0] == snap[LEN-1:0], "R4 snapshot order", dout, snap);
      verify(pad_out == core_out && pad_oe == core_oe, "R4 pads follow core under SAMPLE",
             {pad_oe, pad_out}, {core_oe, core_out});

      // EXTEST selected: pads switch to preload and reset request rises together
      ir_scan(4'b0000, cap);
      verify(pad_out == pvec[NI +: NO] && pad_oe == pvec[NI+NO +: NE],
             "R7 preload drives pads on EXTEST", {pad_oe, pad_out},
             {pvec[NI+NO +: NE], pvec[NI +: NO]});
      verify(sys_rst_req == 1, "R3 reset request in EXTEST", sys_rst_req, 1);

      // EXTEST length, hold during shift, update
      dr_scan(LEN + 8, qvec, dout);
      verify(dout[LEN-1:0] == snap[LEN-1:0], "R2 EXTEST capture", dout, snap);
      verify(dout[LEN +: 8] == qvec[7:0], "R2 chain length", dout[LEN +: 8], qvec[7:0]);
      verify(mid_out == pvec[NI +: NO] && mid_oe == pvec[NI+NO +: NE],
             "R8 pads stable in Shift-DR", {mid_oe, mid_out},
             {pvec[NI+NO +: NE], pvec[NI +: NO]});
      verify(pad_out == qvec[NI+8 +: NO] && pad_oe == qvec[NI+NO+8 +: NE],
             "R7 update drives scanned values", {pad_oe, pad_out},
             {qvec[NI+NO+8 +: NE], qvec[NI+8 +: NO]});

      // CLAMP: latches hold pads, bypass path, no reset request
      ir_scan(4'b1100, cap);
      verify(sys_rst_req == 0, "R3 no reset request in CLAMP", sys_rst_req, 0);
      dr_scan(4, {524'b0, 4'b1111}, dout);
      verify(dout[3:0] == 4'b1110, "R5 R6 CLAMP bypass path", dout[3:0], 4'b1110);
      verify(pad_out == qvec[NI+8 +: NO] && pad_oe == qvec[NI+NO+8 +: NE],
             "R8 R7 CLAMP holds latches", {pad_oe, pad_out},
             {qvec[NI+NO+8 +: NE], qvec[NI+8 +: NO]});

      // TMS route to Test-Logic-Reset
      ir_scan(4'b0000, cap);
      repeat (5) step(1, 0, o);
      verify(sys_rst_req == 0, "R3 no reset request in Test-Logic-Reset", sys_rst_req, 0);
      step(0, 0, o);
      verify(pad_out == core_out && pad_oe == core_oe, "R9 instruction BYPASS after reset",
             {pad_oe, pad_out}, {core_oe, core_out});

      // asynchronous test reset
      ir_scan(4'b0000, cap);
      verify(sys_rst_req == 1, "R3 EXTEST again", sys_rst_req, 1);
      trst_n = 1'b0;
      #3;
      verify(sys_rst_req == 0 && pad_out == core_out, "R10 async reset",
             {sys_rst_req, pad_out}, {1'b0, core_out});
      @(negedge tck);
      #2;
      trst_n = 1'b1;
      step(0, 0, o);
      verify(tdo_en == 0, "R11 tdo_en idle", tdo_en, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule